// File: doc/BRIEF.md
# GPIO Bank with Edge-Triggered Interrupts

This block is one bank of 32 general-purpose pins, grouped into four 8-bit ports named A through D. A 32-bit register port gives the host access to a pin-select word, a direction word, an output/data word, a pending-interrupt word and two interrupt configuration words. The pin-select, direction and output values drive the pad-side outputs. The pin inputs are sampled through a two-flop synchronizer. The block then looks for the configured edge on each pin.

Each pin has one 2-bit interrupt field. The field switches the interrupt off or picks the falling edge, the rising edge or both edges. A detected edge sets the pin's pending bit, and that bit stays set until the host writes a 1 to it. A single interrupt line is raised while any pin is pending. In the one-bit-per-pin words, port A sits in the most significant byte lane, so the host swaps bytes to get pin order. The configuration words hold the two 16-bit halves of their logical value in swapped positions.

Writes take effect on the clock edge where `wr_en` is high. The read data is a combinational function of `addr` and the current state.

Top module: `gpio_edge_bank`

## Requirements
- R1: The pin-select word at offset 0x00 (1 = pin handed to a peripheral, 0 = plain GPIO) stores every written bit, reads back unchanged, and drives `pin_sel` in pin order.
- R2: The direction word at offset 0x08 (1 = output, 0 = input) reads back unchanged and drives `pin_oe` in pin order.
- R3: In the words at 0x00, 0x08, 0x0C and 0x10, pin n appears at register bit 8*(3 - n/8) + n%8, which places port A in bits 31:24 and port D in bits 7:0. The `pin_sel`, `pin_oe` and `pin_out` ports carry pin n on bit n.
- R4: Writing offset 0x0C sets the driven output values on `pin_out`. Reading offset 0x0C returns the driven value for output pins and the synchronized input for input pins.
- R5: Reading offset 0x10 returns the pending bits. Writing offset 0x10 clears each pending bit whose written bit is 1. A written 0 leaves its bit unchanged.
- R6: Offset 0x14 configures pins 0-15 and offset 0x18 configures pins 16-31. Pin n's field sits at logical bits 2*(n%16)+1 : 2*(n%16). Logical bit k is stored at register bit (k+16) mod 32, so the two halves are swapped.
- R7: Interrupt field codes are 00 = off, 01 = falling edge, 10 = rising edge, 11 = both edges. An edge that is not enabled never sets a pending bit.
- R8: Inputs pass through two synchronizing flops. A pin change set up before clock edge k sets its pending bit at edge k+2, and the bit is not visible after edges k or k+1. Detection does not depend on direction or pin select.
- R9: If a new edge and a write-1 clear hit the same pending bit on the same clock edge, the bit stays set.
- R10: `irq` is high exactly while at least one pending bit is set.
- R11: After reset every register reads zero and `irq` is low. Offset 0x04 and other unmapped offsets read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 5 | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pin_in | input | 32 | Pin input levels, pin n on bit n, asynchronous |
| pin_out | output | 32 | Driven output values, pin n on bit n |
| pin_oe | output | 32 | Output enables, pin n on bit n |
| pin_sel | output | 32 | Peripheral hand-over selects, pin n on bit n |
| irq | output | 1 | Combined interrupt, high while any pin is pending |

## Verification
The bench goes after the places where the layout or the timing is easy to get wrong.

- **Byte-lane and half-word placement.** A design that reversed the lanes or left the configuration halves in logical order would report events on the wrong pin, or would arm a neighbouring pin instead.
- **Each edge code.** The bench exercises every code and confirms that a disabled or opposite edge leaves the status word empty. A decoder with swapped code values would flag a falling edge where a rising one was asked for.
- **Event latency.** The bench reads the status after the first, second and third clock edge that follow an input change. A missing or extra synchronizer stage moves the visible set by one cycle.
- **Clear writes.** A clear write is timed onto the same edge as a new event, and a written 0 is also checked. A design that let the clear win, or that cleared on 0, would drop an interrupt.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int LANE_W = 8;
    localparam int LANES  = 4;
    localparam int NPINS  = LANE_W * LANES;
    localparam int AW     = 5;

    localparam logic [AW-1:0] OFF_PSEL = 5'h00;
    localparam logic [AW-1:0] OFF_DIR  = 5'h08;
    localparam logic [AW-1:0] OFF_DATA = 5'h0C;
    localparam logic [AW-1:0] OFF_PEND = 5'h10;
    localparam logic [AW-1:0] OFF_CFGL = 5'h14;
    localparam logic [AW-1:0] OFF_CFGH = 5'h18;

    typedef enum logic [2:0] {
        SEL_PSEL,
        SEL_DIR,
        SEL_DATA,
        SEL_PEND,
        SEL_CFGL,
        SEL_CFGH,
        SEL_NONE
    } reg_sel_e;

    // Reverse byte lanes: lane i of the input goes to lane LANES-1-i.
    function automatic logic [NPINS-1:0] lane_swap(input logic [NPINS-1:0] v);
        logic [NPINS-1:0] r;
        for (int i = 0; i < LANES; i++) begin
            r[(LANES-1-i)*LANE_W +: LANE_W] = v[i*LANE_W +: LANE_W];
        end
        return r;
    endfunction

    // Exchange the upper and lower halves of a configuration word.
    function automatic logic [NPINS-1:0] half_swap(input logic [NPINS-1:0] v);
        return {v[NPINS/2-1:0], v[NPINS-1:NPINS/2]};
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d_async;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIDTH-1:0]   level,
    input  logic [2*WIDTH-1:0] mode,
    output logic [WIDTH-1:0]   hit
);
    logic [WIDTH-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= '0;
        else        last_q <= level;
    end

    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        logic rise, fall;
        assign rise = level[p] & ~last_q[p];
        assign fall = ~level[p] & last_q[p];
        // code bit 1 enables rising, bit 0 enables falling
        assign hit[p] = (mode[2*p+1] & rise) | (mode[2*p] & fall);
    end
endmodule

// File: rtl/gpio_pend_status.sv
module gpio_pend_status #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_v,
    input  logic [WIDTH-1:0] clr_v,
    output logic [WIDTH-1:0] pend,
    output logic             any
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_v) | set_v;
    end

    assign any = |pend;
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = AW,
    parameter int NP     = NPINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [NP-1:0]     wdata,
    output logic [NP-1:0]     rdata,
    input  logic [NP-1:0]     pin_in,
    output logic [NP-1:0]     pin_out,
    output logic [NP-1:0]     pin_oe,
    output logic [NP-1:0]     pin_sel,
    output logic              irq
);
    localparam int CFG_W = 2 * NP;

    reg_sel_e         sel;
    logic [NP-1:0]    psel_q, dir_q, out_q;
    logic [NP-1:0]    cfgl_q, cfgh_q;
    logic [NP-1:0]    sync_in, hit, clr_mask, pend;
    logic [CFG_W-1:0] cfg_logical;
    logic [NP-1:0]    wdata_pins;

    always_comb begin
        if      (addr == ADDR_W'(OFF_PSEL)) sel = SEL_PSEL;
        else if (addr == ADDR_W'(OFF_DIR))  sel = SEL_DIR;
        else if (addr == ADDR_W'(OFF_DATA)) sel = SEL_DATA;
        else if (addr == ADDR_W'(OFF_PEND)) sel = SEL_PEND;
        else if (addr == ADDR_W'(OFF_CFGL)) sel = SEL_CFGL;
        else if (addr == ADDR_W'(OFF_CFGH)) sel = SEL_CFGH;
        else                                sel = SEL_NONE;
    end

    assign wdata_pins = lane_swap(wdata);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psel_q <= '0;
            dir_q  <= '0;
            out_q  <= '0;
            cfgl_q <= '0;
            cfgh_q <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_PSEL: psel_q <= wdata_pins;
                SEL_DIR:  dir_q  <= wdata_pins;
                SEL_DATA: out_q  <= wdata_pins;
                SEL_CFGL: cfgl_q <= wdata;
                SEL_CFGH: cfgh_q <= wdata;
                default:  ;
            endcase
        end
    end

    assign clr_mask    = (wr_en && sel == SEL_PEND) ? wdata_pins : '0;
    assign cfg_logical = {half_swap(cfgh_q), half_swap(cfgl_q)};

    gpio_in_sync #(.WIDTH(NP), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (sync_in)
    );

    gpio_edge_detect #(.WIDTH(NP)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (sync_in),
        .mode  (cfg_logical),
        .hit   (hit)
    );

    gpio_pend_status #(.WIDTH(NP)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .set_v (hit),
        .clr_v (clr_mask),
        .pend  (pend),
        .any   (irq)
    );

    always_comb begin
        unique case (sel)
            SEL_PSEL: rdata = lane_swap(psel_q);
            SEL_DIR:  rdata = lane_swap(dir_q);
            SEL_DATA: rdata = lane_swap((dir_q & out_q) | (~dir_q & sync_in));
            SEL_PEND: rdata = lane_swap(pend);
            SEL_CFGL: rdata = cfgl_q;
            SEL_CFGH: rdata = cfgh_q;
            default:  rdata = '0;
        endcase
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
    assign pin_sel = psel_q;
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk #(
    parameter int NP = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq,
    input logic [NP-1:0] pend,
    input logic [NP-1:0] hit,
    input logic [NP-1:0] clr_mask,
    input logic [2*NP-1:0] cfg_logical
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R9: a detected edge is pending on the next cycle, clear or not
    a_r9_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((pend & $past(hit)) == $past(hit)));

    // R5: a write-1 clear without a competing edge empties the bit
    a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_mask & ~hit)) |=> ((pend & $past(clr_mask & ~hit)) == '0));

    // R8: pending bits never appear without a detected edge
    a_r8_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((pend & ~$past(pend) & ~$past(hit)) == '0));

    // R10: an edge raises the interrupt line next cycle
    a_r10_irq_follows_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> irq);

    // R10: line low means nothing pending
    a_r10_irq_low_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (pend == '0));

    // R7: a pin whose field is off never produces an edge
    for (genvar p = 0; p < NP; p++) begin : g_off
        a_r7_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_logical[2*p +: 2] == 2'b00) |-> !hit[p]);
    end
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.NP(NP)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq         (irq),
    .pend        (pend),
    .hit         (hit),
    .clr_mask    (clr_mask),
    .cfg_logical (cfg_logical)
);

// File: tb/gpio_edge_bank_tb.sv
`timescale 1ns/1ps
module gpio_edge_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe, pin_sel;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] q_data [$];
    logic        q_irq  [$];
    string       q_tag  [$];

    always #2.5 clk = ~clk;

    gpio_edge_bank u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_sel(pin_sel), .irq(irq)
    );

    function automatic logic [31:0] bsw(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [31:0] hsw(input logic [31:0] v);
        return {v[15:0], v[31:16]};
    endfunction

    // monitor: pops scoreboard entries on the falling edge
    always @(negedge clk) begin
        if (q_data.size() > 0) begin
            logic [31:0] ed;
            logic        ei;
            string       tg;
            ed = q_data.pop_front();
            ei = q_irq.pop_front();
            tg = q_tag.pop_front();
            n_tests++;
            if (rdata !== ed || irq !== ei) begin
                n_fail++;
                $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                         tg, rdata, irq, ed, ei);
            end
        end
    end

    task automatic chk_port(input string tg, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tg, act, exp);
        end
    endtask

    // driver tasks start and end at negedge + 1ns
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] ed, input logic ei, input string tg);
        addr = a;
        @(posedge clk);
        q_data.push_back(ed); q_irq.push_back(ei); q_tag.push_back(tg);
        @(negedge clk); #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk); #1;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        finish_run();
    end

    initial begin
        logic [31:0] dir_v, out_v, in_v;
        idle(2);
        @(negedge clk); #1;
        rst_n = 1'b1;
        idle(1);

        // R11: reset values
        rd(5'h00, 32'h0, 1'b0, "R11 reset psel");
        rd(5'h08, 32'h0, 1'b0, "R11 reset dir");
        rd(5'h10, 32'h0, 1'b0, "R11 reset pending");
        rd(5'h14, 32'h0, 1'b0, "R11 reset cfg low");
        rd(5'h18, 32'h0, 1'b0, "R11 reset cfg high");
        chk_port("R11 reset pin_oe", pin_oe, 32'h0);

        // R2 R3: direction, pins 0-7 (port A) outputs
        dir_v = 32'h0000_00FF;
        wr(5'h08, bsw(dir_v));
        rd(5'h08, 32'hFF00_0000, 1'b0, "R2 R3 dir readback lane A high");
        chk_port("R2 pin_oe", pin_oe, dir_v);

        // R1: pin select
        wr(5'h00, bsw(32'h8001_0300));
        rd(5'h00, 32'h0003_0180, 1'b0, "R1 psel readback");
        chk_port("R1 pin_sel", pin_sel, 32'h8001_0300);

        // R4: data mixes driven and synchronized values
        out_v = 32'hFFFF_FFA5;
        wr(5'h0C, bsw(out_v));
        chk_port("R4 pin_out", pin_out, out_v);
        in_v = 32'h1234_5600;
        pin_in = in_v;
        idle(3);
        rd(5'h0C, bsw((dir_v & out_v) | (~dir_v & in_v)), 1'b0, "R4 data read mix");
        rd(5'h10, 32'h0, 1'b0, "R7 no events while all off");
        pin_in = 32'h0;
        idle(3);

        // R11: unmapped offset
        wr(5'h04, 32'hDEAD_BEEF);
        rd(5'h04, 32'h0, 1'b0, "R11 unmapped reads zero");
        rd(5'h00, 32'h0003_0180, 1'b0, "R11 unmapped write left psel");

        // R6: pin8 rising(10), pin9 falling(01); pin20 both(11), pin21 off
        wr(5'h14, hsw(32'h0006_0000));
        wr(5'h18, hsw(32'h0000_0300));
        rd(5'h14, 32'h0000_0006, 1'b0, "R6 cfg low halves swapped");
        rd(5'h18, 32'h0300_0000, 1'b0, "R6 cfg high halves swapped");

        // R8 R7: rising on pin 8, latency check
        pin_in[8] = 1'b1;
        rd(5'h10, 32'h0, 1'b0, "R8 not pending after first edge");
        rd(5'h10, 32'h0, 1'b0, "R8 not pending after second edge");
        rd(5'h10, bsw(32'h1 << 8), 1'b1, "R8 R7 R3 rising pin8 pending at third edge");
        wr(5'h10, bsw(32'h1 << 8));
        rd(5'h10, 32'h0, 1'b0, "R5 write 1 clears, R10 irq drops");
        pin_in[8] = 1'b0;
        idle(4);
        rd(5'h10, 32'h0, 1'b0, "R7 falling ignored on rising-only pin");

        // R7: falling-only pin 9
        pin_in[9] = 1'b1;
        idle(4);
        rd(5'h10, 32'h0, 1'b0, "R7 rising ignored on falling-only pin");
        pin_in[9] = 1'b0;
        idle(4);
        rd(5'h10, bsw(32'h1 << 9), 1'b1, "R7 falling pin9 pending");
        wr(5'h10, 32'h0);
        rd(5'h10, bsw(32'h1 << 9), 1'b1, "R5 write 0 no effect");
        wr(5'h10, 32'hFFFF_FFFF);
        rd(5'h10, 32'h0, 1'b0, "R5 clear all");

        // R7: both edges on pin 20, off pin 21
        pin_in[21] = 1'b1;
        idle(4);
        pin_in[21] = 1'b0;
        idle(4);
        rd(5'h10, 32'h0, 1'b0, "R7 off pin21 never pends");
        pin_in[20] = 1'b1;
        idle(4);
        rd(5'h10, 32'h0000_1000, 1'b1, "R7 R3 both-edge rising pin20");
        wr(5'h10, 32'h0000_1000);
        pin_in[20] = 1'b0;
        idle(4);
        rd(5'h10, 32'h0000_1000, 1'b1, "R7 both-edge falling pin20");

        // R9: edge lands on the same clock edge as its clear
        pin_in[20] = 1'b1;
        @(posedge clk); @(negedge clk); #1;
        @(posedge clk); @(negedge clk); #1;
        wr(5'h10, 32'h0000_1000);
        rd(5'h10, 32'h0000_1000, 1'b1, "R9 edge wins over same-cycle clear");
        wr(5'h10, 32'h0000_1000);
        rd(5'h10, 32'h0, 1'b0, "R9 later clear works");

        // R8: detection independent of direction and pin select (pin 8 set as output)
        wr(5'h08, bsw(32'h0000_0100));
        wr(5'h00, bsw(32'h0000_0100));
        pin_in[8] = 1'b1;
        idle(4);
        rd(5'h10, bsw(32'h1 << 8), 1'b1, "R8 edge seen on output pin");
        rd(5'h0C, bsw(32'h0010_0100), 1'b1, "R4 data read after direction change");

        idle(2);
        finish_run();
    end
endmodule